// File: doc/BRIEF.md
# Double-Buffered Bulk IN Endpoint Packet Buffer

This block is the transmit-side packet store of a USB device bulk IN endpoint. A processor or a DMA engine pushes payload bytes through a write-only data port, one byte per write. Only the low eight bits of each write are stored. The bytes fill one of two packet slots, each 64 bytes deep. A commit strobe closes the slot being filled, records its byte count (0 to 64), and moves loading to the other slot. The loader can therefore queue a second packet while the first one is still on the bus.

The USB transmit engine sees `pkt_ready` and `pkt_len` for the oldest committed packet. It pulls bytes with `rd_en`, and each byte appears on `rd_data` one cycle later. When the host acknowledges the packet, an `ack` pulse frees the slot. A `retry` pulse rewinds the read position to the first byte of the same packet. `svc_req` tells the loader (or its DMA channel) that a slot is free. Writes that arrive while nothing can accept them are dropped, and they set a sticky `overflow` flag.

Top module: `bulk_in_pingpong`

## Requirements
- R1: After synchronous reset, `svc_req` is 1, `pkt_ready` is 0 and `overflow` is 0.
- R2: The bytes written into a slot are read back in the order they were written. Only bits [7:0] of `wr_data` are stored, and the upper bits are ignored.
- R3: A write while both slots hold committed packets is dropped and sets `overflow`. `overflow` then stays 1 until reset, and the queued packets are unchanged.
- R4: `pkt_len` equals the number of bytes written before the commit, from 0 to 64. A 65th write into one slot is dropped and sets `overflow`.
- R5: Packets are offered to the transmitter in the order they were committed.
- R6: An `ack` while `pkt_ready` is 1 frees the oldest slot. From the next cycle the other packet is offered if one is queued, else `pkt_ready` is 0, and `svc_req` is 1.
- R7: A `retry` while `pkt_ready` is 1 makes the next read return the packet's first byte. `pkt_ready` and `pkt_len` are held until `ack`.
- R8: `svc_req` is 1 exactly when at least one slot is empty. It reflects a commit or an `ack` from the cycle after that strobe.
- R9: A byte requested by `rd_en` at a clock edge is on `rd_data` after that edge, and `rd_data` holds until the next accepted read.
- R10: A commit while both slots are full is ignored. An `ack`, `retry` or `rd_en` while `pkt_ready` is 0 is ignored, and `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load one byte from `wr_data` |
| wr_data | input | 32 | Write word; only bits [7:0] are stored |
| commit | input | 1 | Close the slot being loaded and record its length |
| svc_req | output | 1 | At least one slot is free for loading |
| overflow | output | 1 | Sticky: a write was dropped |
| pkt_ready | output | 1 | A committed packet is waiting for transmission |
| pkt_len | output | 7 | Byte count of the offered packet |
| rd_en | input | 1 | Fetch the next byte of the offered packet |
| rd_data | output | 8 | Fetched byte, valid the cycle after `rd_en` |
| ack | input | 1 | Host acknowledged the packet; free the slot |
| retry | input | 1 | Rewind to the first byte of the offered packet |

## Verification
The slot state shows up at the ports in different ways. A wrong full flag or a toggled slot pointer shows in the next cycle as a wrong `pkt_ready`, `pkt_len` or `svc_req`, or as an `overflow` set by a write that should have fit. A wrong read pointer or a write to the wrong address only shows when the packet is drained. The bench therefore compares every drained byte against a model, and it drains after retries and after the two slots have swapped roles. A sticky flag set by mistake never clears, so `overflow` is compared after every operation.

// File: rtl/bip_pkg.sv
package bip_pkg;

  // Bits needed to hold a count from 0 up to and including depth.
  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

  // Bits needed to index depth entries.
  function automatic int idx_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/bip_slot_mem.sv
module bip_slot_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int SLOTS  = 2,
  localparam int ADDR_W = bip_pkg::idx_bits(SLOTS * DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  // Simple dual-port array with a registered read, so that it maps to block RAM.
  logic [DATA_W-1:0] mem [SLOTS*DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/bip_load_ctrl.sv
module bip_load_ctrl #(
  parameter int DEPTH = 64,
  localparam int LEN_W = bip_pkg::cnt_bits(DEPTH),
  localparam int IDX_W = bip_pkg::idx_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             commit,
  input  logic [1:0]       slot_full,
  output logic             mem_we,
  output logic             ld_slot,
  output logic [IDX_W-1:0] ld_idx,
  output logic             commit_fire,
  output logic [LEN_W-1:0] commit_len,
  output logic             drop_wr
);

  logic             sel_q;
  logic [LEN_W-1:0] cnt_q;
  logic             slot_open;
  logic             room;

  // The slot under load is free unless both slots are full.
  assign slot_open   = !slot_full[sel_q];
  assign room        = cnt_q < LEN_W'(DEPTH);
  assign mem_we      = wr_en && slot_open && room;
  assign drop_wr     = wr_en && !mem_we;
  assign commit_fire = commit && slot_open;
  assign commit_len  = cnt_q;
  assign ld_slot     = sel_q;
  assign ld_idx      = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      cnt_q <= '0;
    end else if (commit_fire) begin
      sel_q <= !sel_q;
      cnt_q <= '0;
    end else if (mem_we) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/bip_tx_ctrl.sv
module bip_tx_ctrl #(
  parameter int DEPTH = 64,
  localparam int IDX_W = bip_pkg::idx_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             ack,
  input  logic             retry,
  input  logic [1:0]       slot_full,
  output logic             tx_slot,
  output logic             tx_busy,
  output logic             ack_fire,
  output logic             mem_re,
  output logic [IDX_W-1:0] rd_idx
);

  logic             sel_q;
  logic [IDX_W-1:0] ptr_q;

  assign tx_slot  = sel_q;
  assign tx_busy  = slot_full[sel_q];
  assign ack_fire = ack && tx_busy;
  assign mem_re   = rd_en && tx_busy;
  assign rd_idx   = ptr_q;

  // An ack takes priority over a retry or a read in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      ptr_q <= '0;
    end else if (ack_fire) begin
      sel_q <= !sel_q;
      ptr_q <= '0;
    end else if (retry && tx_busy) begin
      ptr_q <= '0;
    end else if (mem_re) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/bulk_in_pingpong.sv
module bulk_in_pingpong #(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 32,
  parameter int DEPTH  = 64,
  localparam int SLOTS = 2,
  localparam int LEN_W = bip_pkg::cnt_bits(DEPTH),
  localparam int IDX_W = bip_pkg::idx_bits(DEPTH),
  localparam int ADDR_W = bip_pkg::idx_bits(SLOTS * DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              commit,
  output logic              svc_req,
  output logic              overflow,
  output logic              pkt_ready,
  output logic [LEN_W-1:0]  pkt_len,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ack,
  input  logic              retry
);

  logic [SLOTS-1:0] full_q;
  logic [SLOTS-1:0] full_nxt;
  logic [LEN_W-1:0] len_q [SLOTS];

  logic             mem_we, ld_slot, commit_fire, drop_wr;
  logic [IDX_W-1:0] ld_idx;
  logic [LEN_W-1:0] commit_len;
  logic             tx_slot, tx_busy, ack_fire, mem_re;
  logic [IDX_W-1:0] rd_idx;
  logic             unused_hi;

  // The upper bits of the write word carry no data.
  assign unused_hi = ^wr_data[BUS_W-1:DATA_W];

  bip_load_ctrl #(.DEPTH(DEPTH)) load_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .commit(commit), .slot_full(full_q),
    .mem_we(mem_we), .ld_slot(ld_slot), .ld_idx(ld_idx),
    .commit_fire(commit_fire), .commit_len(commit_len), .drop_wr(drop_wr)
  );

  bip_tx_ctrl #(.DEPTH(DEPTH)) tx_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .ack(ack), .retry(retry),
    .slot_full(full_q), .tx_slot(tx_slot), .tx_busy(tx_busy),
    .ack_fire(ack_fire), .mem_re(mem_re), .rd_idx(rd_idx)
  );

  bip_slot_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SLOTS(SLOTS)) mem_i (
    .clk(clk),
    .we(mem_we),
    .waddr(ADDR_W'({ld_slot, ld_idx})),
    .wdata(wr_data[DATA_W-1:0]),
    .re(mem_re),
    .raddr(ADDR_W'({tx_slot, rd_idx})),
    .rdata(rd_data)
  );

  // Per-slot status: a commit fills the slot under load and an ack empties the
  // slot under transmission. The two never hit the same slot in one cycle.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_comb begin
      full_nxt[s] = full_q[s];
      if (commit_fire && (ld_slot == 1'(s)))  full_nxt[s] = 1'b1;
      else if (ack_fire && (tx_slot == 1'(s))) full_nxt[s] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        full_q[s] <= 1'b0;
        len_q[s]  <= '0;
      end else begin
        full_q[s] <= full_nxt[s];
        if (commit_fire && (ld_slot == 1'(s))) len_q[s] <= commit_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_req  <= 1'b1;
      overflow <= 1'b0;
    end else begin
      svc_req  <= !(&full_nxt);
      overflow <= overflow | drop_wr;
    end
  end

  assign pkt_ready = tx_busy;
  assign pkt_len   = len_q[tx_slot];

endmodule

// File: rtl/bip_checker.sv
module bip_checker #(
  parameter int DEPTH = 64,
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             commit,
  input logic             svc_req,
  input logic             overflow,
  input logic             pkt_ready,
  input logic [LEN_W-1:0] pkt_len,
  input logic             ack
);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (svc_req && !pkt_ready && !overflow));

  p_commit_ready_r2: assert property (@(posedge clk) disable iff (rst)
    (commit && svc_req) |=> pkt_ready);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !svc_req) |=> overflow);

  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_len_bound_r4: assert property (@(posedge clk) disable iff (rst)
    pkt_ready |-> (pkt_len <= LEN_W'(DEPTH)));

  p_ack_frees_r6: assert property (@(posedge clk) disable iff (rst)
    (ack && pkt_ready) |=> svc_req);

  p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (pkt_ready && !ack) |=> (pkt_ready && $stable(pkt_len)));

  p_full_means_ready_r8: assert property (@(posedge clk) disable iff (rst)
    !svc_req |-> pkt_ready);

  p_idle_stays_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!pkt_ready && !commit) |=> !pkt_ready);

endmodule

bind bulk_in_pingpong bip_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .commit(commit), .svc_req(svc_req),
  .overflow(overflow), .pkt_ready(pkt_ready), .pkt_len(pkt_len), .ack(ack)
);

// File: tb/bulk_in_pingpong_tb_top.sv
module bulk_in_pingpong_tb_top;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        commit = 1'b0;
  logic        svc_req, overflow, pkt_ready;
  logic [6:0]  pkt_len;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        ack = 1'b0;
  logic        retry = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Independent model of the two packet slots.
  logic [7:0] mp [2][DEPTH];
  int  mlen [2];
  int  mhead, mcnt, mlcnt;
  bit  movf;

  always #4 clk = !clk;

  bulk_in_pingpong dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .commit(commit),
    .svc_req(svc_req), .overflow(overflow), .pkt_ready(pkt_ready),
    .pkt_len(pkt_len), .rd_en(rd_en), .rd_data(rd_data), .ack(ack), .retry(retry)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  function automatic int load_slot();
    return (mhead + mcnt) % 2;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mhead = 0; mcnt = 0; mlcnt = 0; movf = 0;
  endtask

  task automatic do_write(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
    if (mcnt == 2 || mlcnt == DEPTH) movf = 1;
    else begin mp[load_slot()][mlcnt] = v[7:0]; mlcnt++; end
  endtask

  task automatic do_commit();
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    if (mcnt < 2) begin mlen[load_slot()] = mlcnt; mcnt++; mlcnt = 0; end
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    if (mcnt > 0) begin mhead ^= 1; mcnt--; end
  endtask

  task automatic do_retry();
    @(negedge clk); retry = 1'b1;
    @(negedge clk); retry = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic check_status(input string tag);
    chk({tag, " R8 svc_req"}, int'(svc_req), int'(mcnt < 2));
    chk({tag, " R3 overflow"}, int'(overflow), int'(movf));
    chk({tag, " R5 pkt_ready"}, int'(pkt_ready), int'(mcnt > 0));
    if (mcnt > 0) chk({tag, " R4 pkt_len"}, int'(pkt_len), mlen[mhead]);
  endtask

  // Drain the offered packet and compare every byte (R2, R9).
  task automatic drain(input string tag, input int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      read_byte(d);
      chk({tag, " R2 byte"}, int'(d), int'(mp[mhead][i]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, hold;
    int op;
    void'($urandom(32'd51877));
    do_reset();

    // R1: reset state
    chk("R1 svc_req", int'(svc_req), 1);
    chk("R1 pkt_ready", int'(pkt_ready), 0);
    chk("R1 overflow", int'(overflow), 0);

    // R2/R4/R9: short packet, upper write bits carry junk
    do_write(32'hDEAD_BE11); do_write(32'hFFFF_FF22); do_write(32'h1234_5633);
    do_commit();
    check_status("short");
    chk("R4 len3", int'(pkt_len), 3);
    drain("short", 3);
    do_ack();
    chk("R6 ready after ack", int'(pkt_ready), 0);
    chk("R6 svc after ack", int'(svc_req), 1);

    // R10: reads, ack and retry with nothing offered change nothing
    hold = rd_data;
    read_byte(d);
    chk("R10 rd_data held", int'(d), int'(hold));
    do_ack(); do_retry();
    check_status("idle");

    // R4: zero-length packet
    do_commit();
    chk("R4 zero len ready", int'(pkt_ready), 1);
    chk("R4 zero len", int'(pkt_len), 0);
    do_ack();

    // R5/R3/R7/R8/R10: two packets queued, then pressure on the full buffer
    for (int i = 0; i < DEPTH; i++) do_write(32'h100 + i * 7);
    do_commit();
    for (int i = 0; i < 5; i++) do_write(32'hA0 + i);
    do_commit();
    chk("R8 svc low when full", int'(svc_req), 0);
    do_write(32'h55);
    chk("R3 overflow set", int'(overflow), 1);
    do_commit();
    check_status("full");
    chk("R5 oldest len", int'(pkt_len), 64);
    drain("retry-pre", 4);
    do_retry();
    read_byte(d);
    chk("R7 first byte again", int'(d), int'(mp[mhead][0]));
    do_retry();
    drain("pkt64", DEPTH);
    do_ack();
    chk("R5 second offered", int'(pkt_len), 5);
    chk("R6 svc after ack", int'(svc_req), 1);
    drain("pkt5", 5);
    do_ack();
    chk("R10 dropped commit made no packet", int'(pkt_ready), 0);
    chk("R3 overflow sticky", int'(overflow), 1);

    // R4: a 65th byte into one slot is dropped
    do_reset();
    for (int i = 0; i < DEPTH + 1; i++) do_write(32'h3C + i);
    chk("R4 65th byte overflow", int'(overflow), 1);
    do_commit();
    chk("R4 capped len", int'(pkt_len), 64);
    drain("cap", DEPTH);
    do_ack();

    // Random mix against the model
    do_reset();
    for (int n = 0; n < 500; n++) begin
      op = $urandom_range(0, 11);
      if (op < 7) do_write($urandom);
      else if (op < 9) do_commit();
      else if (mcnt > 0) begin
        drain("rand", mlen[mhead]);
        if ($urandom_range(0, 3) == 0 && mlen[mhead] > 0) begin
          do_retry();
          read_byte(d);
          chk("R7 rand retry", int'(d), int'(mp[mhead][0]));
        end
        do_ack();
      end else do_ack();
      check_status("rand");
      if (movf && $urandom_range(0, 1) == 1) do_reset();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule